// File: doc/BRIEF.md
# Power-On Strap Capture and Pad Turnaround Controller

This block reads configuration straps from pins that serve as clock outputs once the chip is up. After reset the shared pads are held as inputs. When the power-good strobe first becomes valid, the block takes one snapshot of the pad levels into a small strap latch. It then turns the pads into outputs, and from that point it gives out per-pad output enables. The same strobe pin, once the capture is done, works as an active-low power-down request. Dropping it removes every output enable quickly. Raising it again brings back the enables that were configured before, and the straps are not sampled again.

The captured value is also the power-up default of a frequency-select register field, which a register write can later replace. The low three bits of that field decide the output mode: outputs off (high impedance), a test bypass, normal, or reserved. A spread-enable request arrives asynchronously and is brought into the clock domain. The pad drivers, PLLs and dividers sit outside this block.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, `pad_oe` is all zeros, `pwr_down` is 0, `strap_q` and `cfg_fsel` are all zeros, `out_mode` is 0, and `spread_on` is 0.
- R2: On the first rise of `pwrgd_pd_n` after reset, `strap_q` takes the levels on `pad_in`. The value is visible after the 4th rising clock edge following the rise: two synchronizer edges, one edge into the capture state, one edge of capture.
- R3: The pads remain inputs (`pad_oe` all zeros) until the capture completes. While the power-good pin is held low after reset, `pad_oe` stays zero. The enables first appear after the 4th edge following the rise of power-good.
- R4: Later power-down and power-up cycles never sample the straps again. `strap_q` keeps its captured value even if `pad_in` changes in the meantime.
- R5: Once capture is done, a low level on `pwrgd_pd_n` clears `pad_oe` to all zeros and sets `pwr_down` by the 2nd rising edge after the fall.
- R6: When `pwrgd_pd_n` rises again during power-down, `pad_oe` returns to the configured enables and `pwr_down` clears after the 3rd rising edge. The straps are left untouched.
- R7: `cfg_fsel` loads the captured straps in the capture cycle. A `cfg_wr_en` pulse after that sets `cfg_fsel` to `cfg_wr_data` on the next edge. `strap_q` is not changed by such a write.
- R8: `out_mode` decodes `cfg_fsel[2:0]` as follows: 000 gives 0 (high impedance), 001 gives 1 (test bypass), 110 gives 3 (reserved), and any other value gives 2 (normal). In mode 0, `pad_oe` is all zeros even when running.
- R9: The output-enable configuration resets to all ones. An `oe_wr_en` pulse loads `oe_wr_data` on the next edge. While running, bit i of that value drives `pad_oe[i]`.
- R10: `spread_on` follows `spread_req` through a two-flop synchronizer and changes after the 2nd rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pad_in | input | STRAP_W | Raw levels of the shared strap pads |
| pwrgd_pd_n | input | 1 | Power-good strobe, later an active-low power-down |
| spread_req | input | 1 | Asynchronous spread-enable request, active high |
| cfg_wr_en | input | 1 | Write strobe for the frequency-select field |
| cfg_wr_data | input | STRAP_W | Value written into the frequency-select field |
| oe_wr_en | input | 1 | Write strobe for the output-enable configuration |
| oe_wr_data | input | NUM_OUT | Value written into the output-enable configuration |
| strap_q | output | STRAP_W | Latched strap levels |
| cfg_fsel | output | STRAP_W | Frequency-select register field |
| pad_oe | output | NUM_OUT | Per-pad output enables (1 = pad drives a clock) |
| pwr_down | output | 1 | Power-down in effect |
| out_mode | output | 2 | Output mode: 0 off, 1 bypass, 2 normal, 3 reserved |
| spread_on | output | 1 | Synchronized spread enable |

## Verification
The bench builds the block with STRAP_W = 3, NUM_OUT = 8 and SYNC_STAGES = 2. Two synchronizer stages give the fixed edge counts that the capture, power-down and restore checks are timed against. Three select bits are enough to reach every output mode, including the high-impedance and reserved codes. Eight enable bits allow asymmetric masks such as 0x5A, so a swapped or dropped bit position shows up at the ports, including after a restore from power-down.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_PG = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_RUN     = 2'd2,
        ST_PDOWN   = 2'd3
    } fsm_state_t;

    typedef enum logic [1:0] {
        MODE_HIZ    = 2'd0,
        MODE_BYPASS = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_RSVD   = 2'd3
    } out_mode_t;

    localparam int MODE_SEL_W = 3;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/strap_mode_dec.sv
module strap_mode_dec
    import strap_pkg::*;
#(
    parameter int STRAP_W = 3
) (
    input  logic [STRAP_W-1:0] fsel,
    output out_mode_t          mode
);
    logic [MODE_SEL_W-1:0] sel;
    assign sel = fsel[MODE_SEL_W-1:0];

    always_comb begin
        unique case (sel)
            3'b000:  mode = MODE_HIZ;
            3'b001:  mode = MODE_BYPASS;
            3'b110:  mode = MODE_RSVD;
            default: mode = MODE_NORMAL;
        endcase
    end
endmodule

// File: rtl/strap_cfg_regs.sv
module strap_cfg_regs #(
    parameter int STRAP_W = 3,
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_en,
    input  logic [STRAP_W-1:0] pad_s,
    input  logic               cfg_wr_en,
    input  logic [STRAP_W-1:0] cfg_wr_data,
    input  logic               oe_wr_en,
    input  logic [NUM_OUT-1:0] oe_wr_data,
    output logic [STRAP_W-1:0] strap_q,
    output logic [STRAP_W-1:0] cfg_fsel,
    output logic [NUM_OUT-1:0] oe_cfg
);
    // strap latch: loaded exactly once per reset, in the capture state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          strap_q <= '0;
        else if (capture_en) strap_q <= pad_s;
    end

    // frequency-select field: strap default, capture has priority over writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cfg_fsel <= '0;
        else if (capture_en) cfg_fsel <= pad_s;
        else if (cfg_wr_en)  cfg_fsel <= cfg_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        oe_cfg <= '1;
        else if (oe_wr_en) oe_cfg <= oe_wr_data;
    end
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
    import strap_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_s,
    input  logic               hiz,
    input  logic [NUM_OUT-1:0] oe_cfg,
    output fsm_state_t         state_q,
    output logic               capture_en,
    output logic [NUM_OUT-1:0] pad_oe,
    output logic               pwr_down
);
    fsm_state_t state_d;
    logic       drive_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_PG;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_PG: if (pg_s)  state_d = ST_CAPTURE;
            ST_CAPTURE:            state_d = ST_RUN;
            ST_RUN:     if (!pg_s) state_d = ST_PDOWN;
            ST_PDOWN:   if (pg_s)  state_d = ST_RUN;
        endcase
    end

    // outputs; the synced strobe gates the enables directly so that
    // power-down takes effect one edge before the state changes
    always_comb begin
        capture_en = 1'b0;
        drive_ok   = 1'b0;
        pwr_down   = 1'b0;
        unique case (state_q)
            ST_WAIT_PG: ;
            ST_CAPTURE: capture_en = 1'b1;
            ST_RUN: begin
                drive_ok = pg_s && !hiz;
                pwr_down = !pg_s;
            end
            ST_PDOWN:   pwr_down = 1'b1;
        endcase
    end

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_oe
            assign pad_oe[i] = drive_ok & oe_cfg[i];
        end
    endgenerate
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int STRAP_W     = 3,
    parameter int NUM_OUT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pad_in,
    input  logic               pwrgd_pd_n,
    input  logic               spread_req,
    input  logic               cfg_wr_en,
    input  logic [STRAP_W-1:0] cfg_wr_data,
    input  logic               oe_wr_en,
    input  logic [NUM_OUT-1:0] oe_wr_data,
    output logic [STRAP_W-1:0] strap_q,
    output logic [STRAP_W-1:0] cfg_fsel,
    output logic [NUM_OUT-1:0] pad_oe,
    output logic               pwr_down,
    output logic [1:0]         out_mode,
    output logic               spread_on
);
    localparam int CTRL_W = 2;

    logic [CTRL_W-1:0]  ctrl_raw;
    logic [CTRL_W-1:0]  ctrl_s;
    logic [STRAP_W-1:0] pad_s;
    logic [NUM_OUT-1:0] oe_cfg;
    logic               pg_s;
    logic               capture_en;
    fsm_state_t         state_q;
    out_mode_t          mode;

    assign ctrl_raw  = {spread_req, pwrgd_pd_n};
    assign pg_s      = ctrl_s[0];
    assign spread_on = ctrl_s[1];

    strap_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) i_ctrl_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ctrl_raw), .d_out(ctrl_s)
    );

    strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) i_pad_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pad_s)
    );

    strap_cfg_regs #(.STRAP_W(STRAP_W), .NUM_OUT(NUM_OUT)) i_regs (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .pad_s(pad_s),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .oe_wr_en(oe_wr_en), .oe_wr_data(oe_wr_data),
        .strap_q(strap_q), .cfg_fsel(cfg_fsel), .oe_cfg(oe_cfg)
    );

    strap_mode_dec #(.STRAP_W(STRAP_W)) i_dec (
        .fsel(cfg_fsel), .mode(mode)
    );

    strap_fsm #(.NUM_OUT(NUM_OUT)) i_fsm (
        .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .hiz(mode == MODE_HIZ),
        .oe_cfg(oe_cfg), .state_q(state_q), .capture_en(capture_en),
        .pad_oe(pad_oe), .pwr_down(pwr_down)
    );

    assign out_mode = mode;
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk
    import strap_pkg::*;
#(
    parameter int STRAP_W = 3,
    parameter int NUM_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwrgd_pd_n,
    input logic               cfg_wr_en,
    input logic [STRAP_W-1:0] cfg_wr_data,
    input logic [STRAP_W-1:0] strap_q,
    input logic [STRAP_W-1:0] cfg_fsel,
    input logic [NUM_OUT-1:0] pad_oe,
    input logic               pwr_down,
    input logic [1:0]         out_mode,
    input fsm_state_t         state_q
);
    a_r3_oe_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe != '0) |-> $past(pwrgd_pd_n, 2));

    a_r5_pd_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwrgd_pd_n, 2) |-> (pad_oe == '0));

    a_r4_straps_hold_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(strap_q));

    a_r4_straps_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(strap_q));

    a_r7_write_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && state_q == ST_RUN) |=> (cfg_fsel == $past(cfg_wr_data)));

    a_r8_hiz_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd0) |-> (pad_oe == '0));
endmodule

bind strap_latch_ctrl strap_latch_chk #(.STRAP_W(STRAP_W), .NUM_OUT(NUM_OUT)) i_chk (
    .clk(clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd_pd_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .strap_q(strap_q), .cfg_fsel(cfg_fsel), .pad_oe(pad_oe),
    .pwr_down(pwr_down), .out_mode(out_mode), .state_q(state_q)
);

// File: tb/test_strap_latch_ctrl.sv
module test_strap_latch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 3;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] pad_in = '0;
    logic          pwrgd_pd_n = 1'b0;
    logic          spread_req = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [SW-1:0] cfg_wr_data = '0;
    logic          oe_wr_en = 1'b0;
    logic [NO-1:0] oe_wr_data = '0;
    logic [SW-1:0] strap_q;
    logic [SW-1:0] cfg_fsel;
    logic [NO-1:0] pad_oe;
    logic          pwr_down;
    logic [1:0]    out_mode;
    logic          spread_on;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_latch_ctrl #(.STRAP_W(SW), .NUM_OUT(NO), .SYNC_STAGES(2)) i_strap_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pwrgd_pd_n(pwrgd_pd_n),
        .spread_req(spread_req), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .oe_wr_en(oe_wr_en), .oe_wr_data(oe_wr_data), .strap_q(strap_q),
        .cfg_fsel(cfg_fsel), .pad_oe(pad_oe), .pwr_down(pwr_down),
        .out_mode(out_mode), .spread_on(spread_on)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [SW-1:0] pads);
        rst_n = 1'b0; pwrgd_pd_n = 1'b0; pad_in = pads;
        spread_req = 1'b0; cfg_wr_en = 1'b0; oe_wr_en = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset_state();
        do_reset(3'b101);
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pwr_down", 32'(pwr_down), 32'h0);
        chk("R1 strap_q", 32'(strap_q), 32'h0);
        chk("R1 cfg_fsel", 32'(cfg_fsel), 32'h0);
        chk("R1 out_mode", 32'(out_mode), 32'h0);
        chk("R1 spread_on", 32'(spread_on), 32'h0);
    endtask

    task automatic t_capture();
        pad_in = 3'b011;
        step(5);
        chk("R3 oe held while pg low", 32'(pad_oe), 32'h0);
        pwrgd_pd_n = 1'b1;
        step(3);
        chk("R3 oe still off edge3", 32'(pad_oe), 32'h0);
        chk("R2 straps not yet edge3", 32'(strap_q), 32'h0);
        step(1);
        chk("R2 strap_q captured", 32'(strap_q), 32'h3);
        chk("R7 cfg_fsel default", 32'(cfg_fsel), 32'h3);
        chk("R3 oe on edge4", 32'(pad_oe), 32'hFF);
        chk("R8 normal mode", 32'(out_mode), 32'h2);
    endtask

    task automatic t_powerdown(input logic [NO-1:0] exp_oe);
        pwrgd_pd_n = 1'b0;
        step(1);
        chk("R5 oe kept edge1", 32'(pad_oe), 32'(exp_oe));
        step(1);
        chk("R5 oe cleared edge2", 32'(pad_oe), 32'h0);
        chk("R5 pwr_down set", 32'(pwr_down), 32'h1);
        pad_in = 3'b100;
        step(4);
        chk("R5 oe low during pd", 32'(pad_oe), 32'h0);
        pwrgd_pd_n = 1'b1;
        step(2);
        chk("R6 oe off edge2", 32'(pad_oe), 32'h0);
        step(1);
        chk("R6 oe restored", 32'(pad_oe), 32'(exp_oe));
        chk("R6 pwr_down clear", 32'(pwr_down), 32'h0);
        chk("R4 straps not resampled", 32'(strap_q), 32'h3);
    endtask

    task automatic t_oe_cfg();
        oe_wr_en = 1'b1; oe_wr_data = 8'h5A;
        step(1);
        oe_wr_en = 1'b0;
        chk("R9 oe mask applied", 32'(pad_oe), 32'h5A);
        t_powerdown(8'h5A);
    endtask

    task automatic wr_fsel(input logic [SW-1:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        step(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic t_modes();
        wr_fsel(3'b001);
        chk("R7 cfg_fsel written", 32'(cfg_fsel), 32'h1);
        chk("R7 strap_q unchanged", 32'(strap_q), 32'h3);
        chk("R8 bypass", 32'(out_mode), 32'h1);
        chk("R8 bypass drives", 32'(pad_oe), 32'h5A);
        wr_fsel(3'b110);
        chk("R8 reserved", 32'(out_mode), 32'h3);
        wr_fsel(3'b000);
        chk("R8 hiz", 32'(out_mode), 32'h0);
        chk("R8 hiz no drive", 32'(pad_oe), 32'h0);
        wr_fsel(3'b111);
        chk("R8 normal 111", 32'(out_mode), 32'h2);
        chk("R8 drive back", 32'(pad_oe), 32'h5A);
    endtask

    task automatic t_spread();
        spread_req = 1'b1;
        step(1);
        chk("R10 spread edge1", 32'(spread_on), 32'h0);
        step(1);
        chk("R10 spread edge2", 32'(spread_on), 32'h1);
        spread_req = 1'b0;
        step(2);
        chk("R10 spread off", 32'(spread_on), 32'h0);
    endtask

    task automatic t_recapture_hiz();
        do_reset(3'b000);
        pwrgd_pd_n = 1'b1;
        step(4);
        chk("R2 strap 000", 32'(strap_q), 32'h0);
        chk("R8 strap hiz mode", 32'(out_mode), 32'h0);
        chk("R8 strap hiz no drive", 32'(pad_oe), 32'h0);
        chk("R9 oe cfg reset", 32'(pad_oe), 32'h0);
        wr_fsel(3'b100);
        chk("R9 reset mask all ones", 32'(pad_oe), 32'hFF);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_capture();
        t_powerdown(8'hFF);
        t_oe_cfg();
        t_modes();
        t_spread();
        t_recapture_hiz();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule